// File: doc/BRIEF.md
# Eight-Point Forward Transform Butterfly Stage (Foldable)

This block is the entry stage of an eight-point forward integer cosine transform. It receives eight signed samples and forms eight intermediate coefficients: the first four are the sums of each sample with its mirror partner (sample i with sample 7-i), and the last four are the matching differences. The results go into eight output registers that are one bit wider than a sample, so no input combination can overflow.

A build parameter chooses how many arithmetic operators the stage spends on this work. The unfolded build has eight operators and finishes in one cycle. The pair-folded build has one adder and one subtractor that handle one mirror pair per cycle, so it needs four cycles. The single-folded build has one add/sub unit that alternates between sum and difference, so it needs eight cycles. A start pulse launches a computation. A one-cycle done pulse marks the point where all eight output registers hold the new vector. The folded builds capture the samples when the start is accepted and ignore further starts until they are finished.

Top module: `bfly8_fold_stage`

## Requirements
- R1: Sample i sits at bits [i*SAMPLE_W +: SAMPLE_W] of `samples_i` and coefficient k at bits [k*(SAMPLE_W+1) +: SAMPLE_W+1] of `coef_o`, both two's complement. Once a computation completes, coefficient i (i = 0..3) equals sample i plus sample 7-i.
- R2: Once a computation completes, coefficient 7-i (i = 0..3) equals sample i minus sample 7-i.
- R3: Coefficients are SAMPLE_W+1 bits wide and stay exact for the most positive and the most negative sample values.
- R4: FOLD_MODE=0 (unfolded) accepts a start on every cycle, never raises `busy_o`, and raises `done_o` in the cycle after the start with all eight coefficients written.
- R5: FOLD_MODE=1 (pair-folded) holds `busy_o` high for exactly 4 cycles after an accepted start and raises `done_o` for one cycle when `busy_o` drops.
- R6: FOLD_MODE=2 (single-folded) holds `busy_o` high for exactly 8 cycles after an accepted start and raises `done_o` for one cycle when `busy_o` drops.
- R7: In the folded modes, a start that arrives while `busy_o` is high is ignored. It changes neither the timing nor the result of the running computation.
- R8: In the folded modes, the samples are captured in the cycle the start is accepted. Later changes on `samples_i` do not affect that result.
- R9: While the stage is idle and no start is given, `coef_o` holds the last completed vector.
- R10: After reset, `busy_o` and `done_o` are low and every coefficient is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; accepted when `busy_o` is low |
| samples_i | input | POINTS*SAMPLE_W | Eight packed signed samples, sample 0 in the low bits |
| busy_o | output | 1 | High while a folded computation is running |
| done_o | output | 1 | One-cycle pulse: the coefficient vector is complete |
| coef_o | output | POINTS*(SAMPLE_W+1) | Eight packed signed coefficients, coefficient 0 in the low bits |

## Verification
All three builds run side by side on the same stimulus: hand-picked vectors, extreme vectors that drive sums and differences to the edges of the wider output range, and a few hundred random vectors with random gaps between starts. The extreme vectors separate a correct one-bit extension from a truncation or a zero extension. Back-to-back starts separate the unfolded build, which accepts every start, from the folded builds, which must drop the starts that fall inside their busy window. A phase that changes the sample bus during a folded run shows whether the operands come from the captured copy or from the live bus.

// File: rtl/bfly8_pkg.sv
`timescale 1ns/1ps
package bfly8_pkg;

   localparam int MODE_PARALLEL = 0;
   localparam int MODE_PAIR     = 1;
   localparam int MODE_SINGLE   = 2;

   // number of operator cycles one transform occupies for a given build
   function automatic int fold_steps(input int mode, input int pts);
      if (mode == MODE_PARALLEL) return 1;
      if (mode == MODE_PAIR)     return pts / 2;
      return pts;
   endfunction

   // counter width able to index every step (at least one bit)
   function automatic int step_width(input int pts);
      return (pts > 2) ? $clog2(pts) : 1;
   endfunction

endpackage

// File: rtl/bfly8_fold_seq.sv
`timescale 1ns/1ps
module bfly8_fold_seq #(
   parameter int STEPS  = 4,
   parameter int STEP_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic              busy_o,
   output logic              wr_o,
   output logic [STEP_W-1:0] step_o,
   output logic              done_o
);

   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

   generate
      if (STEPS == 1) begin : g_single_shot
         // no sequencing: results are written on the start edge
         assign busy_o = 1'b0;
         assign wr_o   = start_i;
         assign step_o = '0;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) done_o <= 1'b0;
            else        done_o <= start_i;
         end
      end else begin : g_counted
         logic              run_q;
         logic [STEP_W-1:0] cnt_q;

         assign busy_o = run_q;
         assign wr_o   = run_q;
         assign step_o = cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q  <= 1'b0;
               cnt_q  <= '0;
               done_o <= 1'b0;
            end else begin
               done_o <= 1'b0;
               if (run_q) begin
                  if (cnt_q == LAST_STEP) begin
                     run_q  <= 1'b0;
                     cnt_q  <= '0;
                     done_o <= 1'b1;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end else if (start_i) begin
                  run_q <= 1'b1;
                  cnt_q <= '0;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/bfly8_sample_hold.sv
`timescale 1ns/1ps
module bfly8_sample_hold #(
   parameter int POINTS   = 8,
   parameter int SAMPLE_W = 12
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         load_i,
   input  logic [POINTS*SAMPLE_W-1:0]   bus_i,
   output logic [POINTS*SAMPLE_W-1:0]   held_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      held_o <= '0;
      else if (load_i) held_o <= bus_i;
   end

endmodule

// File: rtl/bfly8_pair_unit.sv
`timescale 1ns/1ps
module bfly8_pair_unit #(
   parameter int POINTS    = 8,
   parameter int SAMPLE_W  = 12,
   parameter int FOLD_MODE = 0,
   parameter int STEP_W    = 3
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [POINTS*SAMPLE_W-1:0]        samp_i,
   input  logic                              wr_i,
   input  logic [STEP_W-1:0]                 step_i,
   output logic [POINTS*(SAMPLE_W+1)-1:0]    coef_o
);

   import bfly8_pkg::*;

   localparam int COEF_W = SAMPLE_W + 1;
   localparam int HALF   = POINTS / 2;
   localparam int LAST   = POINTS - 1;
   localparam logic [STEP_W-1:0] LAST_IDX = STEP_W'(LAST);

   logic signed [SAMPLE_W-1:0] x      [POINTS];
   logic signed [COEF_W-1:0]   nxt    [POINTS];
   logic                       wr_sel [POINTS];
   logic signed [COEF_W-1:0]   c_q    [POINTS];

   for (genvar i = 0; i < POINTS; i++) begin : g_unpack
      assign x[i] = samp_i[i*SAMPLE_W +: SAMPLE_W];
      assign coef_o[i*COEF_W +: COEF_W] = c_q[i];
   end

   generate
      if (FOLD_MODE == MODE_PARALLEL) begin : g_full
         logic unused_step;
         assign unused_step = ^step_i;

         // four adders and four subtractors, all active together
         for (genvar k = 0; k < POINTS; k++) begin : g_op
            if (k < HALF) begin : g_add
               assign nxt[k] = COEF_W'(x[k]) + COEF_W'(x[LAST-k]);
            end else begin : g_sub
               assign nxt[k] = COEF_W'(x[LAST-k]) - COEF_W'(x[k]);
            end
            assign wr_sel[k] = 1'b1;
         end
      end else if (FOLD_MODE == MODE_PAIR) begin : g_pair
         logic [STEP_W-1:0]        lo_idx, hi_idx;
         logic signed [COEF_W-1:0] opa, opb, sum_v, dif_v;

         assign lo_idx = step_i;
         assign hi_idx = LAST_IDX - step_i;
         assign opa    = COEF_W'(x[lo_idx]);
         assign opb    = COEF_W'(x[hi_idx]);
         // the one shared adder and the one shared subtractor
         assign sum_v  = opa + opb;
         assign dif_v  = opa - opb;

         for (genvar k = 0; k < POINTS; k++) begin : g_steer
            if (k < HALF) begin : g_lo
               assign nxt[k]    = sum_v;
               assign wr_sel[k] = (lo_idx == STEP_W'(k));
            end else begin : g_hi
               assign nxt[k]    = dif_v;
               assign wr_sel[k] = (hi_idx == STEP_W'(k));
            end
         end
      end else begin : g_one
         logic [STEP_W-1:0]        pair_idx, mate_idx, tgt_idx;
         logic                     take_diff;
         logic signed [COEF_W-1:0] opa, opb, res_v;

         assign pair_idx  = step_i >> 1;
         assign take_diff = step_i[0];
         assign mate_idx  = LAST_IDX - pair_idx;
         assign opa       = COEF_W'(x[pair_idx]);
         assign opb       = COEF_W'(x[mate_idx]);
         // the one shared add/sub unit, mode toggling every step
         assign res_v     = take_diff ? (opa - opb) : (opa + opb);
         assign tgt_idx   = take_diff ? mate_idx : pair_idx;

         for (genvar k = 0; k < POINTS; k++) begin : g_steer
            assign nxt[k]    = res_v;
            assign wr_sel[k] = (tgt_idx == STEP_W'(k));
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < POINTS; k++) c_q[k] <= '0;
      end else if (wr_i) begin
         for (int k = 0; k < POINTS; k++) begin
            if (wr_sel[k]) c_q[k] <= nxt[k];
         end
      end
   end

endmodule

// File: rtl/bfly8_fold_stage.sv
`timescale 1ns/1ps
module bfly8_fold_stage #(
   parameter int POINTS    = 8,
   parameter int SAMPLE_W  = 12,
   parameter int FOLD_MODE = 0
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           start_i,
   input  logic [POINTS*SAMPLE_W-1:0]     samples_i,
   output logic                           busy_o,
   output logic                           done_o,
   output logic [POINTS*(SAMPLE_W+1)-1:0] coef_o
);

   import bfly8_pkg::*;

   localparam int STEPS  = fold_steps(FOLD_MODE, POINTS);
   localparam int STEP_W = step_width(POINTS);

   // elaboration-time parameter checks
   generate
      if (POINTS < 2 || (POINTS % 2) != 0) begin : g_bad_points
         $error("POINTS must be even and at least 2");
      end
      if (SAMPLE_W < 2) begin : g_bad_width
         $error("SAMPLE_W must be at least 2");
      end
      if (FOLD_MODE < MODE_PARALLEL || FOLD_MODE > MODE_SINGLE) begin : g_bad_mode
         $error("FOLD_MODE must be 0, 1 or 2");
      end
   endgenerate

   logic                       wr;
   logic [STEP_W-1:0]          step;
   logic [POINTS*SAMPLE_W-1:0] operands;

   bfly8_fold_seq #(
      .STEPS  (STEPS),
      .STEP_W (STEP_W)
   ) seq_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .busy_o  (busy_o),
      .wr_o    (wr),
      .step_o  (step),
      .done_o  (done_o)
   );

   generate
      if (FOLD_MODE == MODE_PARALLEL) begin : g_direct
         assign operands = samples_i;
      end else begin : g_capture
         logic load;
         assign load = start_i & ~busy_o;

         bfly8_sample_hold #(
            .POINTS   (POINTS),
            .SAMPLE_W (SAMPLE_W)
         ) hold_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (load),
            .bus_i  (samples_i),
            .held_o (operands)
         );
      end
   endgenerate

   bfly8_pair_unit #(
      .POINTS    (POINTS),
      .SAMPLE_W  (SAMPLE_W),
      .FOLD_MODE (FOLD_MODE),
      .STEP_W    (STEP_W)
   ) unit_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .samp_i (operands),
      .wr_i   (wr),
      .step_i (step),
      .coef_o (coef_o)
   );

endmodule

// File: rtl/bfly8_stage_chk.sv
`timescale 1ns/1ps
module bfly8_stage_chk #(
   parameter int POINTS    = 8,
   parameter int SAMPLE_W  = 12,
   parameter int FOLD_MODE = 0
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           start_i,
   input logic [POINTS*SAMPLE_W-1:0]     samples_i,
   input logic                           busy_o,
   input logic                           done_o,
   input logic [POINTS*(SAMPLE_W+1)-1:0] coef_o
);

   localparam int COEF_W = SAMPLE_W + 1;
   localparam int STEPS  = bfly8_pkg::fold_steps(FOLD_MODE, POINTS);

   logic [POINTS*SAMPLE_W-1:0] seen_q;
   logic [15:0]                run_len_q;
   logic [POINTS*COEF_W-1:0]   expect_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q    <= '0;
         run_len_q <= '0;
      end else begin
         if (start_i && !busy_o) seen_q <= samples_i;
         run_len_q <= busy_o ? run_len_q + 16'd1 : 16'd0;
      end
   end

   always_comb begin
      for (int i = 0; i < POINTS; i++) begin
         int j;
         int a;
         int b;
         j = POINTS - 1 - i;
         a = int'($signed(seen_q[i*SAMPLE_W +: SAMPLE_W]));
         b = int'($signed(seen_q[j*SAMPLE_W +: SAMPLE_W]));
         expect_vec[i*COEF_W +: COEF_W] = (i < POINTS/2) ? COEF_W'(a + b) : COEF_W'(b - a);
      end
   end

   // R1 R2 R3 R7 R8
   coef_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (coef_o == expect_vec));

   // R5 R6
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R9
   coef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(coef_o));

   generate
      if (FOLD_MODE == bfly8_pkg::MODE_PARALLEL) begin : g_par
         // R4
         never_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !busy_o);
         // R4
         done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            start_i |=> done_o);
      end else begin : g_fold
         // R7
         accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (start_i && !busy_o) |=> busy_o);
         // R5 R6
         run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(busy_o) |-> (run_len_q == 16'(STEPS) && done_o));
         // R5 R6
         done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
            done_o |-> $past(busy_o));
      end
   endgenerate

endmodule

bind bfly8_fold_stage bfly8_stage_chk #(
   .POINTS    (POINTS),
   .SAMPLE_W  (SAMPLE_W),
   .FOLD_MODE (FOLD_MODE)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .samples_i (samples_i),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .coef_o    (coef_o)
);

// File: tb/bfly8_fold_stage_tb_top.sv
`timescale 1ns/1ps
module bfly8_fold_stage_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int PTS        = 8;
   localparam int SW         = 12;
   localparam int CW         = SW + 1;
   localparam int NVAR       = 3;
   localparam int SMAX       = (1 << (SW - 1)) - 1;
   localparam int SMIN       = -(1 << (SW - 1));

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [PTS*SW-1:0] smp_bus = '0;

   logic              busy_w [NVAR];
   logic              done_w [NVAR];
   logic [PTS*CW-1:0] coef_w [NVAR];

   int    total = 0;
   int    bad   = 0;
   string phase = "R10";

   always #(CLK_PERIOD/2) clk = ~clk;

   for (genvar g = 0; g < NVAR; g++) begin : g_var
      bfly8_fold_stage #(
         .POINTS    (PTS),
         .SAMPLE_W  (SW),
         .FOLD_MODE (g)
      ) dut_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .start_i   (start),
         .samples_i (smp_bus),
         .busy_o    (busy_w[g]),
         .done_o    (done_w[g]),
         .coef_o    (coef_w[g])
      );
   end

   // ---------------- behavioural reference ----------------
   int                rem    [NVAR];
   bit                e_done [NVAR];
   int                e_coef [NVAR][PTS];
   logic [PTS*SW-1:0] cap    [NVAR];

   function automatic int samp(input logic [PTS*SW-1:0] v, input int i);
      return int'($signed(v[i*SW +: SW]));
   endfunction

   function automatic int ref_coef(input logic [PTS*SW-1:0] v, input int k);
      if (k < PTS/2) return samp(v, k) + samp(v, PTS-1-k);
      return samp(v, PTS-1-k) - samp(v, k);
   endfunction

   function automatic int run_cycles(input int m);
      return (m == 0) ? 1 : (m == 1) ? 4 : 8;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int m = 0; m < NVAR; m++) begin
            rem[m] = 0;
            e_done[m] = 1'b0;
            cap[m] = '0;
            for (int k = 0; k < PTS; k++) e_coef[m][k] = 0;
         end
      end else begin
         for (int m = 0; m < NVAR; m++) begin
            e_done[m] = 1'b0;
            if (m == 0) begin
               if (start) begin
                  for (int k = 0; k < PTS; k++) e_coef[m][k] = ref_coef(smp_bus, k);
                  e_done[m] = 1'b1;
               end
            end else if (rem[m] > 0) begin
               rem[m] = rem[m] - 1;
               if (rem[m] == 0) begin
                  for (int k = 0; k < PTS; k++) e_coef[m][k] = ref_coef(cap[m], k);
                  e_done[m] = 1'b1;
               end
            end else if (start) begin
               rem[m] = run_cycles(m);
               cap[m] = smp_bus;
            end
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s [%s] %s actual=%0d expected=%0d", req, phase, what, act, exp);
      end
   endtask

   // compare every variant against the reference away from the edge
   always @(negedge clk) begin
      if (rst_n) begin
         for (int m = 0; m < NVAR; m++) begin
            string treq;
            treq = (m == 0) ? "R4" : (m == 1) ? "R5" : "R6";
            check(busy_w[m] == (rem[m] > 0), treq, $sformatf("v%0d busy", m),
                  int'(busy_w[m]), int'(rem[m] > 0));
            check(done_w[m] == e_done[m], treq, $sformatf("v%0d done", m),
                  int'(done_w[m]), int'(e_done[m]));
            if (rem[m] == 0) begin
               for (int k = 0; k < PTS; k++) begin
                  string creq;
                  int    act;
                  act  = int'($signed(coef_w[m][k*CW +: CW]));
                  creq = !e_done[m] ? "R9" : (k < PTS/2) ? "R1" : "R2";
                  check(act == e_coef[m][k], creq, $sformatf("v%0d coef%0d", m, k),
                        act, e_coef[m][k]);
               end
            end
         end
      end
   end

   // ---------------- stimulus ----------------
   function automatic logic [PTS*SW-1:0] pack8(input int v0, input int v1, input int v2,
                                              input int v3, input int v4, input int v5,
                                              input int v6, input int v7);
      logic [PTS*SW-1:0] r;
      int vals [PTS];
      vals = '{v0, v1, v2, v3, v4, v5, v6, v7};
      for (int i = 0; i < PTS; i++) r[i*SW +: SW] = SW'(vals[i]);
      return r;
   endfunction

   function automatic logic [PTS*SW-1:0] rand_vec();
      logic [PTS*SW-1:0] r;
      for (int i = 0; i < PTS; i++) r[i*SW +: SW] = SW'($urandom);
      return r;
   endfunction

   task automatic fire(input logic [PTS*SW-1:0] v);
      @(negedge clk);
      smp_bus = v;
      start   = 1'b1;
      @(negedge clk);
      start   = 1'b0;
   endtask

   task automatic settle();
      repeat (11) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state seen at the ports
      for (int m = 0; m < NVAR; m++) begin
         check(!busy_w[m], "R10", $sformatf("v%0d busy after reset", m), int'(busy_w[m]), 0);
         check(!done_w[m], "R10", $sformatf("v%0d done after reset", m), int'(done_w[m]), 0);
         check(coef_w[m] == '0, "R10", $sformatf("v%0d coef after reset", m),
               int'(coef_w[m] != '0), 0);
      end
      rst_n = 1'b1;
      settle();

      phase = "directed";
      fire(pack8(1, 2, 3, 4, 5, 6, 7, 8));
      settle();
      fire(pack8(-100, 37, 0, -1, 250, -9, 64, 5));
      settle();

      // R3: extremes at both ends of the wider range
      phase = "R3";
      fire(pack8(SMAX, SMAX, SMAX, SMAX, SMAX, SMAX, SMAX, SMAX));
      settle();
      fire(pack8(SMIN, SMIN, SMIN, SMIN, SMIN, SMIN, SMIN, SMIN));
      settle();
      fire(pack8(SMAX, SMAX, SMAX, SMAX, SMIN, SMIN, SMIN, SMIN));
      settle();
      fire(pack8(SMIN, SMIN, SMIN, SMIN, SMAX, SMAX, SMAX, SMAX));
      settle();

      // R7: second start inside the busy window is dropped by folded builds
      phase = "R7";
      fire(pack8(11, -22, 33, -44, 55, -66, 77, -88));
      fire(pack8(SMAX, 0, SMIN, 0, 1, -1, 2, -2));
      settle();

      // R8: live bus changes after the accepted start
      phase = "R8";
      fire(pack8(300, -300, 200, -200, 100, -100, 50, -50));
      for (int c = 0; c < 9; c++) begin
         smp_bus = rand_vec();
         @(negedge clk);
      end
      settle();

      // R4 R7: start held high for many cycles in a row
      phase = "R4";
      @(negedge clk);
      start = 1'b1;
      for (int c = 0; c < 20; c++) begin
         smp_bus = rand_vec();
         @(negedge clk);
      end
      start = 1'b0;
      settle();

      // R1 R2 R9: random vectors with random gaps
      phase = "random";
      for (int n = 0; n < 300; n++) begin
         fire(rand_vec());
         repeat ($urandom_range(0, 10)) @(negedge clk);
      end
      settle();

      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog [%s] run did not finish actual=%0d expected=%0d", phase, 1, 0);
      finish_run();
   end

endmodule